// File: doc/BRIEF.md
# Directed-Rounding Mantissa Incrementer

This block finishes the rounding step of a floating-point result. It takes an unsigned mantissa that carries two extra low-order bits, a guard bit above a round bit, together with a separate sticky bit, the sign of the result and a two-bit rounding-mode select. It discards the two extra bits and decides whether to add one at the new least significant position. It returns the rounded mantissa, a flag that says an increment was applied, and a flag that says precision was lost.

The carry of the increment runs across the whole kept field. The output is one bit wider than the kept field, so an all-ones mantissa that rounds up shows up as a set top bit. The block makes no correction for that case; the caller renormalises and adjusts the exponent. The block is combinational. A parameter can add a single register stage on the outputs.

Top module: `dir_round_inc`

## Requirements
- R1: Bits [1:0] of `mant_in` are removed before any increment, with bit 1 as guard and bit 0 as round. When no increment is applied, `mant_out` equals `{1'b0, mant_in[MANT_W-1:2]}`.
- R2: When guard, round and sticky are all zero, no increment is applied and `inexact_out` is 0, in every mode.
- R3: When guard, round or sticky is set, `inexact_out` is 1, in every mode.
- R4: Mode 2'b00 rounds to nearest. It increments only when guard is 1 and at least one of round, sticky or the kept LSB `mant_in[2]` is 1, so an exact tie goes to the even value.
- R5: Mode 2'b01 rounds toward zero and never increments.
- R6: Mode 2'b10 (toward plus infinity) increments only when the result is inexact and `sign_in` is 0. Mode 2'b11 (toward minus infinity) increments only when the result is inexact and `sign_in` is 1.
- R7: The increment carries through the full kept field. A kept field of all ones that is incremented gives `mant_out` with only bit MANT_W-2 set.
- R8: `round_up_out` is 1 exactly when an increment was applied, and `mant_out` then equals the kept field plus one.
- R9: With OUT_REG=1, every output shows the result for the inputs of the previous clock cycle, and all outputs are 0 while `rst_n` is low. With OUT_REG=0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| mant_in | input | MANT_W | Mantissa with guard at bit 1 and round at bit 0 |
| sticky_in | input | 1 | OR of all bits lost below the round bit |
| sign_in | input | 1 | Sign of the result, 1 = negative |
| mode_in | input | 2 | 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| mant_out | output | MANT_W-1 | Rounded kept field, including the carry-out bit |
| round_up_out | output | 1 | An increment was applied |
| inexact_out | output | 1 | Guard, round or sticky was set |

## Verification
The bench builds two copies with MANT_W=8: one with OUT_REG=0 and one with OUT_REG=1. Both get the same stimulus and are checked against one model, so the combinational path and the one-cycle registered path are compared directly. The narrow width of six kept bits means random vectors often hit an all-ones kept field. That makes the carry into the extra bit, and ties with both odd and even LSBs, likely under every mode and sign, alongside the directed cases.

// File: rtl/dir_round_inc.sv
module dir_round_inc #(
  parameter int MANT_W  = 26,
  parameter bit OUT_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MANT_W-1:0] mant_in,
  input  logic              sticky_in,
  input  logic              sign_in,
  input  logic [1:0]        mode_in,
  output logic [MANT_W-2:0] mant_out,
  output logic              round_up_out,
  output logic              inexact_out
);
  localparam int KEEP_W = MANT_W - 2;
  localparam int OUT_W  = KEEP_W + 1;

  localparam logic [1:0] MODE_NEAR = 2'b00;
  localparam logic [1:0] MODE_ZERO = 2'b01;
  localparam logic [1:0] MODE_POS  = 2'b10;
  localparam logic [1:0] MODE_NEG  = 2'b11;

  logic [KEEP_W-1:0] kept;
  logic              guard_b, round_b, lost;
  logic              bump;
  logic [OUT_W-1:0]  sum;

  assign kept    = mant_in[MANT_W-1:2];
  assign guard_b = mant_in[1];
  assign round_b = mant_in[0];
  assign lost    = guard_b | round_b | sticky_in;

  always_comb begin
    unique case (mode_in)
      MODE_NEAR: bump = guard_b & (round_b | sticky_in | kept[0]);
      MODE_ZERO: bump = 1'b0;
      MODE_POS:  bump = lost & ~sign_in;
      MODE_NEG:  bump = lost & sign_in;
      default:   bump = guard_b & (round_b | sticky_in | kept[0]);
    endcase
  end

  assign sum = {1'b0, kept} + {{KEEP_W{1'b0}}, bump};

  generate
    if (OUT_REG) begin : g_reg
      logic [OUT_W-1:0] mant_q;
      logic             up_q, inx_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mant_q <= '0;
          up_q   <= 1'b0;
          inx_q  <= 1'b0;
        end else begin
          mant_q <= sum;
          up_q   <= bump;
          inx_q  <= lost;
        end
      end
      assign mant_out     = mant_q;
      assign round_up_out = up_q;
      assign inexact_out  = inx_q;
    end else begin : g_comb
      assign mant_out     = sum;
      assign round_up_out = bump;
      assign inexact_out  = lost;
    end
  endgenerate
endmodule

// File: rtl/dir_round_inc_chk.sv
module dir_round_inc_chk #(
  parameter int MANT_W  = 26,
  parameter bit OUT_REG = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MANT_W-1:0] mant_in,
  input logic              sticky_in,
  input logic              sign_in,
  input logic [1:0]        mode_in,
  input logic [MANT_W-2:0] mant_out,
  input logic              round_up_out,
  input logic              inexact_out
);
  localparam int KEEP_W = MANT_W - 2;

  // R8 / R3: an increment is only ever a response to lost precision
  p_up_needs_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    round_up_out |-> inexact_out);

  // R7: the carry-out bit can only appear on a round-up
  p_carry_only_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mant_out[KEEP_W] |-> round_up_out);

  generate
    if (OUT_REG) begin : g_lat1
      p_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mant_in[1:0] == 2'b00 && !sticky_in) |=> (!inexact_out && !round_up_out));
      p_loss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (mant_in[1:0] != 2'b00 || sticky_in)) |=> inexact_out);
      p_rz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode_in == 2'b01) |=> !round_up_out);
      p_pos_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode_in == 2'b10 && sign_in) |=> !round_up_out);
      p_neg_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode_in == 2'b11 && !sign_in) |=> !round_up_out);
      p_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (mant_out == {1'b0, $past(mant_in[MANT_W-1:2])} + {{KEEP_W{1'b0}}, round_up_out}));
    end else begin : g_lat0
      p_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mant_in[1:0] == 2'b00 && !sticky_in) |-> (!inexact_out && !round_up_out));
      p_loss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mant_in[1:0] != 2'b00 || sticky_in) |-> inexact_out);
      p_rz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_in == 2'b01) |-> !round_up_out);
      p_pos_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_in == 2'b10 && sign_in) |-> !round_up_out);
      p_neg_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_in == 2'b11 && !sign_in) |-> !round_up_out);
      p_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mant_out == {1'b0, mant_in[MANT_W-1:2]} + {{KEEP_W{1'b0}}, round_up_out});
    end
  endgenerate
endmodule

bind dir_round_inc dir_round_inc_chk #(.MANT_W(MANT_W), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .mant_in(mant_in), .sticky_in(sticky_in),
  .sign_in(sign_in), .mode_in(mode_in), .mant_out(mant_out),
  .round_up_out(round_up_out), .inexact_out(inexact_out)
);

// File: tb/dir_round_inc_bench.sv
module dir_round_inc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] mant_in = '0;
  logic sticky_in = 1'b0, sign_in = 1'b0;
  logic [1:0] mode_in = 2'b00;

  logic [W-2:0] c_mant, r_mant;
  logic c_up, c_inx, r_up, r_inx;

  int checks = 0, failures = 0;
  logic [W:0] pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  dir_round_inc #(.MANT_W(W), .OUT_REG(1'b1)) u_dir_round_inc (
    .clk(clk), .rst_n(rst_n), .mant_in(mant_in), .sticky_in(sticky_in),
    .sign_in(sign_in), .mode_in(mode_in), .mant_out(r_mant),
    .round_up_out(r_up), .inexact_out(r_inx));

  dir_round_inc #(.MANT_W(W), .OUT_REG(1'b0)) u_dir_round_inc_comb (
    .clk(clk), .rst_n(rst_n), .mant_in(mant_in), .sticky_in(sticky_in),
    .sign_in(sign_in), .mode_in(mode_in), .mant_out(c_mant),
    .round_up_out(c_up), .inexact_out(c_inx));

  function automatic logic [W:0] model(input logic [W-1:0] m, input logic st,
                                       input logic sg, input logic [1:0] md);
    int unsigned kept, gr, res;
    bit loss, bump;
    kept = m >> 2;
    gr   = m & 3;
    loss = (gr != 0) || st;
    case (md)
      2'b00: bump = (gr == 3) || (gr == 2 && (st || (kept % 2 == 1)));
      2'b01: bump = 1'b0;
      2'b10: bump = loss && !sg;
      default: bump = loss && sg;
    endcase
    res = kept + (bump ? 1 : 0);
    return {bump, loss, res[W-2:0]};
  endfunction

  task automatic chk(input string tag, input logic [W:0] got, input logic [W:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // drive at a falling edge, check comb now, registered one cycle later
  task automatic apply(input string tag, input logic [W-1:0] m, input logic st,
                       input logic sg, input logic [1:0] md);
    mant_in = m; sticky_in = st; sign_in = sg; mode_in = md;
    pend = model(m, st, sg, md);
    #1;
    chk(tag, {c_up, c_inx, c_mant}, pend);
    @(negedge clk);
    chk({tag, " R9 reg"}, {r_up, r_inx, r_mant}, pend);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    mant_in = 8'hFF; sticky_in = 1'b1; mode_in = 2'b00;
    repeat (3) @(negedge clk);
    chk("R9 reset", {r_up, r_inx, r_mant}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    apply("R1 drop gr",       8'b1011_0100, 1'b0, 1'b0, 2'b00);
    apply("R2 exact near",    8'b0110_1000, 1'b0, 1'b0, 2'b00);
    apply("R2 exact pos",     8'b0110_1000, 1'b0, 1'b0, 2'b10);
    apply("R2 exact neg",     8'b0110_1000, 1'b0, 1'b1, 2'b11);
    apply("R3 sticky only",   8'b0000_0100, 1'b1, 1'b0, 2'b01);
    apply("R3 round only",    8'b0000_0101, 1'b0, 1'b1, 2'b01);
    apply("R4 tie even",      8'b0000_1010, 1'b0, 1'b0, 2'b00);
    apply("R4 tie odd",       8'b0000_0110, 1'b0, 1'b0, 2'b00);
    apply("R4 above half",    8'b0000_1011, 1'b0, 1'b0, 2'b00);
    apply("R4 half+sticky",   8'b0000_1010, 1'b1, 1'b0, 2'b00);
    apply("R4 below half",    8'b0000_1001, 1'b1, 1'b1, 2'b00);
    apply("R5 zero all set",  8'b0101_0111, 1'b1, 1'b0, 2'b01);
    apply("R6 pos positive",  8'b0000_0001, 1'b0, 1'b0, 2'b10);
    apply("R6 pos negative",  8'b0000_0011, 1'b1, 1'b1, 2'b10);
    apply("R6 neg negative",  8'b0000_0001, 1'b0, 1'b1, 2'b11);
    apply("R6 neg positive",  8'b0000_0011, 1'b1, 1'b0, 2'b11);
    apply("R7 carry near",    8'b1111_1111, 1'b0, 1'b0, 2'b00);
    apply("R7 carry pos",     8'b1111_1100, 1'b1, 1'b0, 2'b10);
    apply("R7 carry neg",     8'b1111_1101, 1'b0, 1'b1, 2'b11);
    apply("R8 no carry zero", 8'b1111_1111, 1'b1, 1'b1, 2'b01);

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] md;
      md = 2'($urandom);
      case (md)
        2'b00: apply("R4 random", 8'($urandom), 1'($urandom), 1'($urandom), md);
        2'b01: apply("R5 random", 8'($urandom), 1'($urandom), 1'($urandom), md);
        default: apply("R6 random", 8'($urandom), 1'($urandom), 1'($urandom), md);
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule